// File: doc/BRIEF.md
# FIFO Read Strobe and Frame-Start Pulse Generator

This block runs the parallel-port handshake that drains camera frame data from an external FIFO into a downstream processor array. A start command puts it into readout mode. Each frame transfer then opens with a single frame-start pulse. After that pulse, the block issues one read strobe for every word in the frame. Each read strobe pops one word from the FIFO and also tells the consumer that the data on the bus is valid. Once the last word has been strobed, the next frame begins on its own. The block stays in readout mode until an abort arrives.

The frame-start pulse width, the read pulse width and the number of words per frame are inputs, counted in clock ticks of 40 ns at the intended 25 MHz clock. A zero width is treated as one tick. A read strobe is only issued when the FIFO reports data. If the block waits too long for data, it raises a sticky timeout flag, drops the rest of the frame and starts a new frame, without leaving readout mode. The default wait limit is 65 ms.

Top module: `frame_strobe_gen`

## Requirements
- R1: After reset, frame_pulse_o, rd_strobe_o and timeout_o are low. They stay low until start_i is sampled high.
- R2: Each frame-start pulse lasts max(frame_pw_i, 1) clock cycles.
- R3: Each read strobe lasts max(read_pw_i, 1) clock cycles.
- R4: Every frame has the following order:
  - one frame-start pulse;
  - then exactly max(word_cnt_i, 1) read strobes;
  - then the next frame-start pulse, with no further strobe in between.
- R5: A read strobe rises only after a cycle in which fifo_empty_i was sampled low (0 = data present). While fifo_empty_i is high, no strobe is issued.
- R6: The output stays low for at least MIN_GAP cycles in two places: between two read strobes, and between the end of a frame-start pulse and the first read strobe. The default MIN_GAP is 3 (120 ns).
- R7: The timeout behaves as follows:
  - When the block has waited TMO_TICKS consecutive cycles for data with fifo_empty_i high, timeout_o goes high.
  - The frame is abandoned, and a new frame-start pulse begins in that same cycle.
  - A shorter stall raises no timeout.
- R8: timeout_o stays high until one of two events clears it: an abort, or a start accepted while idle. A start received during readout has no effect.
- R9: When abort_i is sampled high, both pulse outputs are low from the next cycle on, and the block waits for a new start. Abort wins over a start in the same cycle.
- R10: Each pulse width is taken when the pulse begins. Changing the width input during a pulse does not change that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per 40 ns at 25 MHz |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Enter readout mode (acted on only when idle) |
| abort_i | input | 1 | Leave readout mode, return to idle |
| fifo_empty_i | input | 1 | External FIFO empty flag, 1 = no data |
| frame_pw_i | input | 16 | Frame-start pulse width in ticks |
| read_pw_i | input | 16 | Read strobe width in ticks |
| word_cnt_i | input | 16 | Words per frame |
| frame_pulse_o | output | 1 | Frame-start pulse |
| rd_strobe_o | output | 1 | FIFO pop and consumer data-valid strobe |
| timeout_o | output | 1 | Sticky readout stall flag |

## Verification
The main frame sequence is run with several sets of widths and word counts while the FIFO always has data. This set includes:
- zero values, which separate the one-tick clamp from a literal zero-cycle pulse;
- single-word frames, which expose off-by-one errors in the word counter;
- the 2000/5 tick register defaults.

A held empty flag is applied for two different durations: one shorter than the wait limit and one longer. The shorter stall must only delay the strobe. The longer stall must raise the timeout and restart the frame while staying in readout mode. Aborts are applied in three situations: idle together with a start, in the middle of a strobe, and after a timeout. Width inputs are also changed in the middle of a pulse.

// File: rtl/frame_strobe_pkg.sv
package frame_strobe_pkg;

    localparam int PW_W = 16;
    localparam int WC_W = 16;

    typedef logic [PW_W-1:0] pw_t;
    typedef logic [WC_W-1:0] wc_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FRAME = 3'd1,
        S_GAP   = 3'd2,
        S_WAIT  = 3'd3,
        S_READ  = 3'd4
    } state_t;

    // Zero-valued widths are raised to one tick.
    function automatic pw_t clamp_pw(input pw_t w);
        return (w == '0) ? pw_t'(1) : w;
    endfunction

    function automatic wc_t clamp_wc(input wc_t w);
        return (w == '0) ? wc_t'(1) : w;
    endfunction

endpackage

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q > W'(1))
            cnt_q <= cnt_q - W'(1);
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/fsg_stall_watch.sv
module fsg_stall_watch #(
    parameter int LIMIT = 1625000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen
    import frame_strobe_pkg::*;
#(
    parameter int MIN_GAP   = 3,
    parameter int TMO_TICKS = 1625000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        abort_i,
    input  logic        fifo_empty_i,
    input  logic [15:0] frame_pw_i,
    input  logic [15:0] read_pw_i,
    input  logic [15:0] word_cnt_i,
    output logic        frame_pulse_o,
    output logic        rd_strobe_o,
    output logic        timeout_o
);
    localparam int  GAP_EFF = (MIN_GAP < 1) ? 1 : MIN_GAP;
    localparam pw_t GAP_LD  = pw_t'(GAP_EFF);

    state_t st_q, st_d;
    wc_t    words_q;
    logic   tmo_q;

    logic   t_load, t_last;
    pw_t    t_val;
    logic   words_load, words_dec, tmo_set, stall_exp;

    fsg_pulse_timer #(.W(PW_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    fsg_stall_watch #(.LIMIT(TMO_TICKS)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q == S_WAIT),
        .expired (stall_exp)
    );

    always_comb begin
        st_d       = st_q;
        t_load     = 1'b0;
        t_val      = clamp_pw(frame_pw_i);
        words_load = 1'b0;
        words_dec  = 1'b0;
        tmo_set    = 1'b0;
        case (st_q)
            S_IDLE: if (start_i) begin
                st_d       = S_FRAME;
                t_load     = 1'b1;
                words_load = 1'b1;
            end
            S_FRAME: if (t_last) begin
                st_d   = S_GAP;
                t_load = 1'b1;
                t_val  = GAP_LD;
            end
            S_GAP: if (t_last) begin
                if (words_q == '0) begin
                    st_d       = S_FRAME;
                    t_load     = 1'b1;
                    words_load = 1'b1;
                end else begin
                    st_d = S_WAIT;
                end
            end
            S_WAIT: if (!fifo_empty_i) begin
                st_d   = S_READ;
                t_load = 1'b1;
                t_val  = clamp_pw(read_pw_i);
            end else if (stall_exp) begin
                st_d       = S_FRAME;
                t_load     = 1'b1;
                words_load = 1'b1;
                tmo_set    = 1'b1;
            end
            S_READ: if (t_last) begin
                st_d      = S_GAP;
                t_load    = 1'b1;
                t_val     = GAP_LD;
                words_dec = 1'b1;
            end
            default: st_d = S_IDLE;
        endcase
        if (abort_i) begin
            st_d       = S_IDLE;
            t_load     = 1'b0;
            words_load = 1'b0;
            words_dec  = 1'b0;
            tmo_set    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            words_q <= '0;
            tmo_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (words_load)
                words_q <= clamp_wc(word_cnt_i);
            else if (words_dec)
                words_q <= words_q - wc_t'(1);
            if (abort_i || (st_q == S_IDLE && start_i))
                tmo_q <= 1'b0;
            else if (tmo_set)
                tmo_q <= 1'b1;
        end
    end

    assign frame_pulse_o = (st_q == S_FRAME);
    assign rd_strobe_o   = (st_q == S_READ);
    assign timeout_o     = tmo_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int MIN_GAP = 3
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic abort_i,
    input logic fifo_empty_i,
    input logic frame_pulse_o,
    input logic rd_strobe_o,
    input logic timeout_o
);
    int gap_q;

    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= MIN_GAP;
        else if (rd_strobe_o)
            gap_q <= 0;
        else if (gap_q < MIN_GAP)
            gap_q <= gap_q + 1;
    end

    // R5
    strobe_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe_o) |-> !$past(fifo_empty_i));

    // R6
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe_o) |-> (gap_q >= MIN_GAP));

    // R7
    timeout_restarts_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> frame_pulse_o);

    // R8
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o && !abort_i && !start_i |=> timeout_o);

    // R9
    abort_quiets_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !frame_pulse_o && !rd_strobe_o);
endmodule

bind frame_strobe_gen fsg_checker #(.MIN_GAP(MIN_GAP)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .abort_i       (abort_i),
    .fifo_empty_i  (fifo_empty_i),
    .frame_pulse_o (frame_pulse_o),
    .rd_strobe_o   (rd_strobe_o),
    .timeout_o     (timeout_o)
);

// File: tb/sim_frame_strobe_gen.sv
`timescale 1ns/1ps
module sim_frame_strobe_gen;
    localparam int MIN_GAP = 3;
    localparam int TMO     = 40;

    // {frame width, read width, words}; second row checks zero clamping,
    // last row uses the 2000/5 tick register defaults.
    localparam int VEC [5][3] = '{
        '{1, 1, 1}, '{0, 0, 2}, '{4, 2, 3}, '{7, 3, 4}, '{2000, 5, 2}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, abort_i = 1'b0, fifo_empty_i = 1'b0;
    logic [15:0] fs_w = 16'd2, rd_w = 16'd1, wc = 16'd2;
    logic frame_pulse_o, rd_strobe_o, timeout_o;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    frame_strobe_gen #(.MIN_GAP(MIN_GAP), .TMO_TICKS(TMO)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .fifo_empty_i(fifo_empty_i), .frame_pw_i(fs_w), .read_pw_i(rd_w),
        .word_cnt_i(wc), .frame_pulse_o(frame_pulse_o),
        .rd_strobe_o(rd_strobe_o), .timeout_o(timeout_o)
    );

    function automatic int cl(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_abort();
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    endtask

    task automatic check_frame(input int efs, input int erd, input int nw);
        int hi, lo;
        while (!frame_pulse_o) @(negedge clk);
        hi = 0;
        while (frame_pulse_o) begin hi++; @(negedge clk); end
        chk(hi == efs, "R2", hi, efs);
        for (int w = 0; w < nw; w++) begin
            lo = 0;
            while (!rd_strobe_o && !frame_pulse_o) begin lo++; @(negedge clk); end
            chk(rd_strobe_o == 1'b1, "R4", int'(rd_strobe_o), 1);
            chk(lo >= MIN_GAP, "R6", lo, MIN_GAP);
            hi = 0;
            while (rd_strobe_o) begin hi++; @(negedge clk); end
            chk(hi == erd, "R3", hi, erd);
        end
        while (!rd_strobe_o && !frame_pulse_o) @(negedge clk);
        chk(frame_pulse_o == 1'b1, "R4", int'(frame_pulse_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R4: watchdog expired, actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lo, hi, seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state and idle hold
        chk({frame_pulse_o, rd_strobe_o, timeout_o} == 3'b000, "R1",
            int'({frame_pulse_o, rd_strobe_o, timeout_o}), 0);
        seen = 0;
        repeat (20) begin @(negedge clk); seen += int'(frame_pulse_o | rd_strobe_o); end
        chk(seen == 0, "R1", seen, 0);

        // Table-driven frame sequences, FIFO always holding data
        for (int v = 0; v < 5; v++) begin
            fs_w = 16'(VEC[v][0]); rd_w = 16'(VEC[v][1]); wc = 16'(VEC[v][2]);
            pulse_start();
            check_frame(cl(VEC[v][0]), cl(VEC[v][1]), cl(VEC[v][2]));
            do_abort();
            // R9 outputs low after abort
            chk(!frame_pulse_o && !rd_strobe_o, "R9",
                int'(frame_pulse_o | rd_strobe_o), 0);
        end

        // R9 abort beats simultaneous start
        start_i = 1'b1; abort_i = 1'b1; @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        seen = 0;
        repeat (10) begin seen += int'(frame_pulse_o | rd_strobe_o); @(negedge clk); end
        chk(seen == 0, "R9", seen, 0);

        // R9 abort in the middle of a strobe
        fs_w = 16'd2; rd_w = 16'd8; wc = 16'd3;
        pulse_start();
        while (!rd_strobe_o) @(negedge clk);
        do_abort();
        chk(!frame_pulse_o && !rd_strobe_o, "R9", int'(frame_pulse_o | rd_strobe_o), 0);
        seen = 0;
        repeat (20) begin seen += int'(frame_pulse_o | rd_strobe_o); @(negedge clk); end
        chk(seen == 0, "R9", seen, 0);

        // R10 width change during pulse
        fs_w = 16'd6;
        pulse_start();
        hi = 0;
        while (frame_pulse_o) begin
            hi++;
            if (hi == 2) fs_w = 16'd20;
            @(negedge clk);
        end
        chk(hi == 6, "R10", hi, 6);
        do_abort();

        // R5 short stall delays strobe, no timeout
        fs_w = 16'd2; rd_w = 16'd1; wc = 16'd2; fifo_empty_i = 1'b1;
        pulse_start();
        while (frame_pulse_o) @(negedge clk);
        seen = 0;
        repeat (10) begin seen += int'(rd_strobe_o); @(negedge clk); end
        chk(seen == 0, "R5", seen, 0);
        fifo_empty_i = 1'b0;
        lo = 0;
        while (!rd_strobe_o && lo < 10) begin lo++; @(negedge clk); end
        chk(rd_strobe_o == 1'b1, "R5", int'(rd_strobe_o), 1);
        chk(timeout_o == 1'b0, "R7", int'(timeout_o), 0);
        do_abort();

        // R7 long stall: timeout, frame restarted, mode kept
        fifo_empty_i = 1'b1;
        pulse_start();
        while (frame_pulse_o) @(negedge clk);
        lo = 0;
        while (!frame_pulse_o && !rd_strobe_o && lo < 1000) begin lo++; @(negedge clk); end
        chk(rd_strobe_o == 1'b0, "R5", int'(rd_strobe_o), 0);
        chk(frame_pulse_o == 1'b1, "R7", int'(frame_pulse_o), 1);
        chk(lo >= TMO && lo <= TMO + MIN_GAP, "R7", lo, TMO);
        chk(timeout_o == 1'b1, "R7", int'(timeout_o), 1);
        fifo_empty_i = 1'b0;
        check_frame(2, 1, 2);
        chk(timeout_o == 1'b1, "R8", int'(timeout_o), 1);
        pulse_start();
        chk(timeout_o == 1'b1, "R8", int'(timeout_o), 1);
        do_abort();
        chk(timeout_o == 1'b0, "R8", int'(timeout_o), 0);
        chk(!frame_pulse_o && !rd_strobe_o, "R9", int'(frame_pulse_o | rd_strobe_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule